// File: doc/BRIEF.md
# Dual-Enable Byte Memory Bus Controller with Power-Fail Lockout

This block sits behind the strobe pins of a byte-wide static memory. It samples the host's asynchronous strobes with a system clock. The strobes are an active-low select, an active-high select, an active-low output enable and an active-low write enable. From them the block decides, on every clock, whether the part is idle, being read, being written or locked out. It owns a byte array with one location for each address value. It returns read data on a data output that has a separate drive-enable, which is meant to control a three-state pad.

A write is framed by the strobes. The window is open only while both selects are asserted and the write enable is low. The window therefore opens on whichever of those three events comes last and closes on whichever release comes first. The byte is committed once, when the window closes. It uses the address and data seen during the last sampled cycle in which the window was open.

A digital power-fail flag overrides everything. While the flag is high, the bus is released and nothing can be written. A write that sees the flag at any point while its window is open is dropped, even if the flag clears before the window closes.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset, `dq_oe` is 0 and `dq_out` is 0.
- R2: With `ce1_n`=0, `ce2`=1, `we_n`=1 and `oe_n`=0 held, `dq_oe` becomes 1 and `dq_out` carries the stored byte at `addr`, SYNC_STAGES+1 clocks after the inputs settle.
- R3: `dq_oe` is 1 only when the sampled strobes were `ce1_n`=0, `ce2`=1, `oe_n`=0, `we_n`=1 and `pwr_fail`=0 one clock earlier. Raising `oe_n` alone, or lowering `ce2` alone, keeps the bus released.
- R4: `dq_oe` returns to 0 one clock after a deselecting condition is sampled, that is SYNC_STAGES+1 clocks after the pin changes. It is still 1 one clock before that.
- R5: A write stores the data and address of the last sampled cycle in which its window was open. The data may change while the window is open.
- R6: The window closes, and the byte is stored, on whichever of `we_n` rising, `ce1_n` rising or `ce2` falling happens first. Each of the three releases commits a write.
- R7: No window exists until all three of `ce1_n`=0, `ce2`=1 and `we_n`=0 hold together. Strobes that never overlap store nothing, and the addressed byte is unchanged.
- R8: A low `we_n` during an active read releases the bus. A cycle in which the selects, `oe_n` and `we_n` all assert together never drives the bus.
- R9: While `pwr_fail` is 1, `dq_oe` is 0 and no byte can be written.
- R10: If `pwr_fail` is seen at any time while a write window is open, that write is discarded, even if `pwr_fail` clears before the window closes.
- R11: The array holds 2**ADDR_W bytes (ADDR_W defaults to 11 and is legal up to 13, which gives 8192 bytes). A write changes only its own address; the highest address is usable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_fail | input | 1 | Supply out-of-tolerance flag, active high |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | DATA_W | Write data from the bus |
| dq_out | output | DATA_W | Read data toward the bus (0 while released) |
| dq_oe | output | 1 | Drive enable for the data pad |

## Verification
The hardest case to reach is a power-fail pulse that starts and ends inside a single write window. In that case the strobes still look like a clean, complete write when the window closes. The bench holds `we_n` low, pulses `pwr_fail` for two clocks, waits with the flag clear, and only then releases `we_n`. It then reads the location back and expects the earlier value. A second hard case is a write in which `we_n` falls together with the selects and `oe_n`. For that one the bench samples `dq_oe` on every clock of the window, not only at the end.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [1:0] {
      BUS_IDLE   = 2'd0,
      BUS_READ   = 2'd1,
      BUS_WRITE  = 2'd2,
      BUS_LOCKED = 2'd3
   } bus_mode_e;

   typedef struct packed {
      logic pf;
      logic we_n;
      logic oe_n;
      logic ce2;
      logic ce1_n;
   } strobe_t;

   localparam strobe_t STROBE_REST = '{pf: 1'b0, we_n: 1'b1, oe_n: 1'b1,
                                       ce2: 1'b0, ce1_n: 1'b1};

endpackage

// File: rtl/sram_strobe_sampler.sv
module sram_strobe_sampler #(
   parameter int STAGES = 2,
   parameter int W      = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] chain [STAGES+1];

   assign chain[0] = d;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[g+1] <= RST_VAL;
         else        chain[g+1] <= chain[g];
      end
   end

   assign q = chain[STAGES];

endmodule

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
   import sram_ctl_pkg::*;
(
   input  strobe_t   st,
   output bus_mode_e mode
);

   always_comb begin
      if (st.pf)                         mode = BUS_LOCKED;
      else if (st.ce1_n || !st.ce2)      mode = BUS_IDLE;
      else if (st.we_n)                  mode = BUS_READ;
      else                               mode = BUS_WRITE;
   end

endmodule

// File: rtl/sram_write_window.sv
module sram_write_window
   import sram_ctl_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  strobe_t           st,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);

   logic open_now;
   logic open_q;
   logic poison_q;

   // Window ignores the power flag so that a flag pulse cannot split one
   // host write into two.
   assign open_now = !st.ce1_n && st.ce2 && !st.we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q   <= 1'b0;
         poison_q <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         open_q   <= open_now;
         poison_q <= open_now ? (poison_q || st.pf) : 1'b0;
         if (open_now && !st.pf) begin
            wr_addr <= addr;
            wr_data <= din;
         end
      end
   end

   assign wr_en = open_q && !open_now && !poison_q && !st.pf;

endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      rd_data <= mem[rd_addr];
   end

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
   import sram_ctl_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_fail,
   input  logic              ce1_n,
   input  logic              ce2,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);

   localparam int ST_W  = $bits(strobe_t);
   localparam int BUS_W = ST_W + ADDR_W + DATA_W;

   if (ADDR_W < 1 || ADDR_W > 13) begin : g_bad_addr
      $error("sram_bus_ctrl: ADDR_W must lie in 1..13");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("sram_bus_ctrl: DATA_W must be positive");
   end
   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("sram_bus_ctrl: SYNC_STAGES must lie in 1..4");
   end

   strobe_t           st_raw;
   strobe_t           st_s;
   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] din_s;
   logic [BUS_W-1:0]  bus_raw;
   logic [BUS_W-1:0]  bus_s;
   bus_mode_e         mode;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] rd_data;
   logic              oe_q;

   assign st_raw  = '{pf: pwr_fail, we_n: we_n, oe_n: oe_n, ce2: ce2, ce1_n: ce1_n};
   assign bus_raw = {st_raw, addr, dq_in};

   sram_strobe_sampler #(
      .STAGES  (SYNC_STAGES),
      .W       (BUS_W),
      .RST_VAL ({STROBE_REST, {(ADDR_W+DATA_W){1'b0}}})
   ) u_sampler (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bus_raw),
      .q     (bus_s)
   );

   assign {st_s, addr_s, din_s} = bus_s;

   sram_mode_decode u_decode (
      .st   (st_s),
      .mode (mode)
   );

   sram_write_window #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .st      (st_s),
      .addr    (addr_s),
      .din     (din_s),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data)
   );

   sram_byte_array #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_array (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (addr_s),
      .rd_data (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= (mode == BUS_READ) && !st_s.oe_n;
   end

   assign dq_oe  = oe_q;
   assign dq_out = oe_q ? rd_data : '0;

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic s_pf,
   input logic s_ce1_n,
   input logic s_ce2,
   input logic s_oe_n,
   input logic s_we_n,
   input logic wr_en,
   input logic dq_oe
);

   a_r3_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> $past(!s_ce1_n && s_ce2 && !s_oe_n && s_we_n && !s_pf));

   a_r4_release_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ce1_n || !s_ce2) |=> !dq_oe);

   a_r8_write_strobe_releases: assert property (@(posedge clk) disable iff (!rst_n)
      !s_we_n |=> !dq_oe);

   a_r9_lockout_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      s_pf |=> !dq_oe);

   a_r9_lockout_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      s_pf |-> !wr_en);

   a_r6_store_on_close: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(!s_ce1_n && s_ce2 && !s_we_n) && (s_ce1_n || !s_ce2 || s_we_n));

   a_r10_flag_clear_before_store: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(!s_pf));

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .s_pf    (st_s.pf),
   .s_ce1_n (st_s.ce1_n),
   .s_ce2   (st_s.ce2),
   .s_oe_n  (st_s.oe_n),
   .s_we_n  (st_s.we_n),
   .wr_en   (wr_en),
   .dq_oe   (dq_oe)
);

// File: tb/sram_bus_ctrl_tb.sv
module sram_bus_ctrl_tb;

   localparam int AW  = 11;
   localparam int DW  = 8;
   localparam int SYN = 2;
   localparam int LAT = SYN + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pwr_fail = 1'b0;
   logic          ce1_n = 1'b1;
   logic          ce2 = 1'b0;
   logic          oe_n = 1'b1;
   logic          we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out;
   logic          dq_oe;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 0;

   typedef struct {
      logic          oe;
      logic [DW-1:0] val;
      string         req;
   } exp_t;
   exp_t exp_q[$];

   always #5 clk = ~clk;

   sram_bus_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SYN)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_fail (pwr_fail),
      .ce1_n    (ce1_n),
      .ce2      (ce2),
      .oe_n     (oe_n),
      .we_n     (we_n),
      .addr     (addr),
      .dq_in    (dq_in),
      .dq_out   (dq_out),
      .dq_oe    (dq_oe)
   );

   // driver side: queue what the ports must show now
   task automatic expect_bus(input logic oe, input logic [DW-1:0] val, input string req);
      exp_t e;
      e.oe = oe; e.val = val; e.req = req;
      exp_q.push_back(e);
   endtask

   // monitor side: pop and compare at a falling edge
   task automatic monitor_pop();
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (dq_oe !== e.oe || (e.oe && dq_out !== e.val)) begin
         n_fails++;
         $display("FAIL %s: oe=%0b data=%02h expected oe=%0b data=%02h",
                  e.req, dq_oe, dq_out, e.oe, e.val);
      end
   endtask

   task automatic check_now(input logic oe, input logic [DW-1:0] val, input string req);
      expect_bus(oe, val, req);
      monitor_pop();
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_bus();
      ce1_n = 1'b1; ce2 = 1'b0; oe_n = 1'b1; we_n = 1'b1;
      wait_n(LAT + 1);
   endtask

   task automatic read_check(input logic [AW-1:0] a, input logic [DW-1:0] v, input string req);
      addr = a; we_n = 1'b1; ce1_n = 1'b0; ce2 = 1'b1; oe_n = 1'b0;
      wait_n(LAT);
      check_now(1'b1, v, req);
      idle_bus();
   endtask

   task automatic write_we(input logic [AW-1:0] a, input logic [DW-1:0] v);
      addr = a; dq_in = v; oe_n = 1'b1; ce1_n = 1'b0; ce2 = 1'b1;
      wait_n(1);
      we_n = 1'b0;
      wait_n(3);
      we_n = 1'b1;
      wait_n(1);
      idle_bus();
   endtask

   initial begin
      wait_n(3);
      check_now(1'b0, '0, "R1 reset");
      if (dq_out !== '0) begin
         n_fails++;
         $display("FAIL R1: dq_out=%02h expected 00", dq_out);
      end
      rst_n = 1'b1;
      wait_n(2);

      // R2 / R5 / R6: plain write closed by we_n, read back
      write_we(11'h010, 8'hA5);
      read_check(11'h010, 8'hA5, "R2 R6 read after we_n-closed write");

      // R6: close by ce1_n rising
      addr = 11'h123; dq_in = 8'h3C; we_n = 1'b0; ce2 = 1'b1; wait_n(1);
      ce1_n = 1'b0; wait_n(3);
      ce1_n = 1'b1; wait_n(1);
      idle_bus();
      read_check(11'h123, 8'h3C, "R6 ce1_n-closed write");

      // R6 / R11: close by ce2 falling, top address
      addr = 11'h7FF; dq_in = 8'hC3; we_n = 1'b0; ce1_n = 1'b0; wait_n(1);
      ce2 = 1'b1; wait_n(3);
      ce2 = 1'b0; wait_n(1);
      idle_bus();
      read_check(11'h7FF, 8'hC3, "R6 R11 ce2-closed write at top address");

      // R5: data changes inside the window, last value wins
      addr = 11'h050; dq_in = 8'h10; ce1_n = 1'b0; ce2 = 1'b1; wait_n(1);
      we_n = 1'b0; wait_n(3);
      dq_in = 8'h20; wait_n(3);
      we_n = 1'b1; wait_n(1);
      idle_bus();
      read_check(11'h050, 8'h20, "R5 last data in window");

      // R7: strobes never overlap -> nothing stored
      write_we(11'h200, 8'h77);
      addr = 11'h200; dq_in = 8'h11; we_n = 1'b0; ce1_n = 1'b0; ce2 = 1'b0;
      wait_n(5);
      ce1_n = 1'b1; wait_n(2);
      idle_bus();
      read_check(11'h200, 8'h77, "R7 no window without all three");

      // R3: oe_n high, or ce2 low, keeps bus released
      addr = 11'h010; ce1_n = 1'b0; ce2 = 1'b1; oe_n = 1'b1; we_n = 1'b1;
      wait_n(LAT + 1);
      check_now(1'b0, '0, "R3 oe_n high");
      oe_n = 1'b0; ce2 = 1'b0;
      wait_n(LAT + 1);
      check_now(1'b0, '0, "R3 ce2 low");
      idle_bus();

      // R4: release timing on deselect
      addr = 11'h010; ce1_n = 1'b0; ce2 = 1'b1; oe_n = 1'b0;
      wait_n(LAT);
      check_now(1'b1, 8'hA5, "R2 read before deselect");
      ce1_n = 1'b1;
      wait_n(LAT - 1);
      check_now(1'b1, 8'hA5, "R4 still driven one clock before release");
      wait_n(1);
      check_now(1'b0, '0, "R4 released");
      idle_bus();

      // R8: we_n low during a read releases the bus
      addr = 11'h010; dq_in = 8'hA5; ce1_n = 1'b0; ce2 = 1'b1; oe_n = 1'b0;
      wait_n(LAT);
      check_now(1'b1, 8'hA5, "R8 read active");
      we_n = 1'b0;
      wait_n(LAT);
      check_now(1'b0, '0, "R8 released by we_n");
      we_n = 1'b1; wait_n(1);
      idle_bus();

      // R8: everything asserts together -> never driven
      addr = 11'h060; dq_in = 8'h66;
      ce1_n = 1'b0; ce2 = 1'b1; oe_n = 1'b0; we_n = 1'b0;
      for (int i = 0; i < 6; i++) begin
         wait_n(1);
         check_now(1'b0, '0, "R8 simultaneous write stays released");
      end
      we_n = 1'b1; oe_n = 1'b1; wait_n(1);
      idle_bus();
      read_check(11'h060, 8'h66, "R8 simultaneous write stored");

      // R9: power-fail lockout
      pwr_fail = 1'b1;
      addr = 11'h010; ce1_n = 1'b0; ce2 = 1'b1; oe_n = 1'b0; we_n = 1'b1;
      wait_n(LAT + 1);
      check_now(1'b0, '0, "R9 no drive while locked");
      idle_bus();
      write_we(11'h010, 8'h5A);
      pwr_fail = 1'b0;
      wait_n(LAT);
      read_check(11'h010, 8'hA5, "R9 write blocked while locked");

      // R10: flag pulse inside the window aborts the write
      write_we(11'h020, 8'h42);
      addr = 11'h020; dq_in = 8'h99; ce1_n = 1'b0; ce2 = 1'b1; wait_n(1);
      we_n = 1'b0; wait_n(3);
      pwr_fail = 1'b1; wait_n(2);
      pwr_fail = 1'b0; wait_n(4);
      we_n = 1'b1; wait_n(1);
      idle_bus();
      read_check(11'h020, 8'h42, "R10 aborted write");

      // R11: write to address 0 leaves the top address alone
      write_we(11'h000, 8'h01);
      read_check(11'h000, 8'h01, "R11 address zero");
      read_check(11'h7FF, 8'hC3, "R11 top address untouched");

      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule